// File: doc/BRIEF.md
# Commit Signature Accumulator and Cross-Core Checker

This block sits at the retirement end of one of two cores that run the same thread redundantly. Every cycle the commit stage can hand it up to two architectural effects. The first is an address-class item: a load address, a store address or a resolved branch target. The second is a data-class item: a register write value or store data. Both are folded into a running 32-bit CRC signature, so the full commit stream is reduced to one word that the two cores can exchange cheaply.

A comparison starts on any of three single-cycle requests: an I/O operation waiting to issue, an overflow of unverified lines in the data cache, or the end of a verification interval. The block then holds retirement, presents its signature to the partner core and waits for the partner's signature. Equal signatures give a one-cycle match pulse, which allows a checkpoint. Different signatures, or no partner signature before a programmable limit, give a one-cycle error pulse, which requests a restore. After either outcome the signature restarts from all ones.

Top module: `cfp_unit`

## Requirements
- R1: While reset is held and in the cycle after it, `commit_stall`, `local_fp_vld`, `fp_match` and `fp_error` are 0 and `local_fp` is 0xFFFFFFFF.
- R2: Outside an exchange, an item with its valid set updates `local_fp` at the next clock edge. The update is a non-reflected CRC over the 32-bit item, most significant bit first, with polynomial 0x04C11DB7 and no final inversion. The result is equal to XORing the item into the signature and then doing 32 shift-left steps, each of which XORs in the polynomial when the bit shifted out was 1.
- R3: When the address item and the data item are both valid in the same cycle, the address is folded first and the data second.
- R4: A request on `req_io`, `req_ovf` or `req_intv` outside an exchange raises `commit_stall` and `local_fp_vld` from the next cycle. Both stay high until the cycle in which the outcome pulse appears, and drop in that cycle.
- R5: Items that are valid in the same cycle as the request are included in the exchanged signature. Items presented while `commit_stall` is high leave `local_fp` unchanged.
- R6: A partner signature that is valid during an exchange and equal to `local_fp` produces `fp_match` for exactly one cycle, starting the cycle after. In that same cycle `local_fp` returns to 0xFFFFFFFF.
- R7: A partner signature that is valid during an exchange and differs from `local_fp` produces `fp_error` for one cycle, starting the cycle after. In that same cycle `local_fp` returns to 0xFFFFFFFF.
- R8: Number the exchange cycles from 0. If no partner signature is valid by cycle `tmo_limit`, `fp_error` is raised after that cycle, so the stall lasts `tmo_limit`+1 cycles. A partner signature that arrives in cycle `tmo_limit` takes priority over the timeout.
- R9: Requests that arrive while an exchange is running are ignored. They do not start another exchange after the current one ends.
- R10: `fp_match` and `fp_error` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cm_addr_vld | input | 1 | Address-class commit item valid |
| cm_addr | input | 32 | Load or store address, or branch target |
| cm_data_vld | input | 1 | Data-class commit item valid |
| cm_data | input | 32 | Register write value or store data |
| req_io | input | 1 | I/O operation pending, compare first |
| req_ovf | input | 1 | Unverified-line overflow in data cache |
| req_intv | input | 1 | Verification interval ended |
| tmo_limit | input | TMO_W | Last exchange cycle that may accept the partner signature |
| peer_fp | input | 32 | Partner core signature |
| peer_fp_vld | input | 1 | Partner signature valid |
| local_fp | output | 32 | Running local signature |
| local_fp_vld | output | 1 | Local signature offered to partner |
| commit_stall | output | 1 | Retirement must hold |
| fp_match | output | 1 | Signatures agreed, checkpoint permitted |
| fp_error | output | 1 | Mismatch or timeout, restore requested |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a comparison request together with valid commit items. The bench provokes it on every exchange by driving both items with the request, and judges it by requiring the offered signature to include those items. The second pair is the partner signature arriving in the very cycle the timeout expires. For several limits the bench delivers the partner signature in exchange cycle `tmo_limit` and expects a match pulse with no error. Separate runs without a partner signature measure the stall length against `tmo_limit`+1.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    localparam int unsigned FP_W = 32;
    localparam logic [FP_W-1:0] FP_SEED = '1;

    typedef logic [FP_W-1:0] fp_t;

    typedef struct packed {
        logic vld;
        fp_t  word;
    } item_t;

    typedef enum logic [0:0] {
        PH_RUN  = 1'b0,
        PH_XCHG = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        VD_NONE  = 2'd0,
        VD_MATCH = 2'd1,
        VD_MISS  = 2'd2,
        VD_LATE  = 2'd3
    } verdict_e;

    // XOR the word in, then 32 polynomial shift steps (MSB first, no reflection)
    function automatic fp_t crc_word(fp_t crc, fp_t word, fp_t poly);
        fp_t c;
        c = crc ^ word;
        for (int i = 0; i < int'(FP_W); i++) begin
            c = c[FP_W-1] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/cfp_fold.sv
module cfp_fold
    import cfp_pkg::*;
#(
    parameter int unsigned LANES = 2,
    parameter fp_t         POLY  = 32'h04C11DB7
) (
    input  fp_t                    seed,
    input  item_t [LANES-1:0]      items,
    output fp_t                    result
);

    // lane 0 is folded first, the highest lane last
    fp_t chain [LANES+1];

    assign chain[0] = seed;

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        assign chain[g+1] = items[g].vld ? crc_word(chain[g], items[g].word, POLY)
                                         : chain[g];
    end

    assign result = chain[LANES];

endmodule

// File: rtl/cfp_sync_ctrl.sv
module cfp_sync_ctrl
    import cfp_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             peer_vld,
    input  logic             peer_eq,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             in_xchg,
    output logic             resolve,
    output verdict_e         verdict
);

    phase_e           ph_q;
    logic [TMO_W-1:0] wait_q;
    verdict_e         vd_q;
    verdict_e         vd_n;
    logic             expired;

    assign expired = (wait_q == tmo_limit);

    always_comb begin
        vd_n = VD_NONE;
        if (ph_q == PH_XCHG) begin
            if (peer_vld) begin
                vd_n = peer_eq ? VD_MATCH : VD_MISS;
            end else if (expired) begin
                vd_n = VD_LATE;
            end
        end
    end

    assign resolve = (ph_q == PH_XCHG) && (peer_vld || expired);
    assign in_xchg = (ph_q == PH_XCHG);
    assign verdict = vd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_RUN;
            wait_q <= '0;
            vd_q   <= VD_NONE;
        end else begin
            vd_q <= vd_n;
            case (ph_q)
                PH_RUN: begin
                    wait_q <= '0;
                    if (trig) begin
                        ph_q <= PH_XCHG;
                    end
                end
                PH_XCHG: begin
                    if (resolve) begin
                        ph_q   <= PH_RUN;
                        wait_q <= '0;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                default: ph_q <= PH_RUN;
            endcase
        end
    end

endmodule

// File: rtl/cfp_unit.sv
module cfp_unit
    import cfp_pkg::*;
#(
    parameter int unsigned TMO_W = 16,
    parameter logic [31:0] POLY  = 32'h04C11DB7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cm_addr_vld,
    input  logic [31:0]      cm_addr,
    input  logic             cm_data_vld,
    input  logic [31:0]      cm_data,
    input  logic             req_io,
    input  logic             req_ovf,
    input  logic             req_intv,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic [31:0]      peer_fp,
    input  logic             peer_fp_vld,
    output logic [31:0]      local_fp,
    output logic             local_fp_vld,
    output logic             commit_stall,
    output logic             fp_match,
    output logic             fp_error
);

    localparam int unsigned LANES = 2;

    fp_t               acc_q;
    fp_t               folded;
    item_t [LANES-1:0] items;
    logic              in_xchg;
    logic              resolve;
    verdict_e          verdict;

    // address lane precedes data lane
    assign items[0] = '{vld: cm_addr_vld, word: cm_addr};
    assign items[1] = '{vld: cm_data_vld, word: cm_data};

    cfp_fold #(
        .LANES (LANES),
        .POLY  (POLY)
    ) u_fold (
        .seed   (acc_q),
        .items  (items),
        .result (folded)
    );

    cfp_sync_ctrl #(
        .TMO_W (TMO_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trig      (req_io | req_ovf | req_intv),
        .peer_vld  (peer_fp_vld),
        .peer_eq   (peer_fp == acc_q),
        .tmo_limit (tmo_limit),
        .in_xchg   (in_xchg),
        .resolve   (resolve),
        .verdict   (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= FP_SEED;
        end else if (resolve) begin
            acc_q <= FP_SEED;
        end else if (!in_xchg) begin
            acc_q <= folded;
        end
    end

    assign local_fp     = acc_q;
    assign local_fp_vld = in_xchg;
    assign commit_stall = in_xchg;
    assign fp_match     = (verdict == VD_MATCH);
    assign fp_error     = (verdict == VD_MISS) || (verdict == VD_LATE);

endmodule

// File: rtl/cfp_chk.sv
module cfp_chk #(
    parameter int unsigned TMO_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_io,
    input logic             req_ovf,
    input logic             req_intv,
    input logic [TMO_W-1:0] tmo_limit,
    input logic [31:0]      peer_fp,
    input logic             peer_fp_vld,
    input logic [31:0]      local_fp,
    input logic             commit_stall,
    input logic             fp_match,
    input logic             fp_error
);

    logic [TMO_W:0] stall_run;

    always_ff @(posedge clk) begin
        if (rst || !commit_stall) begin
            stall_run <= '0;
        end else begin
            stall_run <= stall_run + 1'b1;
        end
    end

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fp_match && fp_error)); // R10
    AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fp_match |=> !fp_match); // R6
    AST_ERROR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fp_error |=> !fp_error); // R7
    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(commit_stall) |-> $past(req_io || req_ovf || req_intv)); // R4
    AST_STALL_END: assert property (@(posedge clk) disable iff (rst)
        $fell(commit_stall) |-> (fp_match || fp_error)); // R4
    AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (commit_stall && $past(commit_stall)) |-> $stable(local_fp)); // R5
    AST_MATCH_REASON: assert property (@(posedge clk) disable iff (rst)
        fp_match |-> $past(peer_fp_vld && commit_stall && (peer_fp == local_fp))); // R6
    AST_SIG_RESTART: assert property (@(posedge clk) disable iff (rst)
        (fp_match || fp_error) |-> (local_fp == 32'hFFFFFFFF)); // R7
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        commit_stall |-> (stall_run <= {1'b0, tmo_limit})); // R8

endmodule

bind cfp_unit cfp_chk #(.TMO_W(TMO_W)) u_chk (.*);

// File: tb/cfp_unit_tb.sv
module cfp_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] POLY_TB = 32'h04C11DB7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cm_addr_vld = 1'b0;
    logic [31:0] cm_addr = '0;
    logic        cm_data_vld = 1'b0;
    logic [31:0] cm_data = '0;
    logic        req_io = 1'b0;
    logic        req_ovf = 1'b0;
    logic        req_intv = 1'b0;
    logic [15:0] tmo_limit = 16'd10;
    logic [31:0] peer_fp = '0;
    logic        peer_fp_vld = 1'b0;
    logic [31:0] local_fp;
    logic        local_fp_vld;
    logic        commit_stall;
    logic        fp_match;
    logic        fp_error;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] model = 32'hFFFFFFFF;
    logic [31:0] lfsr = 32'h1234_5678;

    cfp_unit u_dut (
        .clk(clk), .rst(rst),
        .cm_addr_vld(cm_addr_vld), .cm_addr(cm_addr),
        .cm_data_vld(cm_data_vld), .cm_data(cm_data),
        .req_io(req_io), .req_ovf(req_ovf), .req_intv(req_intv),
        .tmo_limit(tmo_limit), .peer_fp(peer_fp), .peer_fp_vld(peer_fp_vld),
        .local_fp(local_fp), .local_fp_vld(local_fp_vld),
        .commit_stall(commit_stall), .fp_match(fp_match), .fp_error(fp_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // bit-serial reference: one message bit per step
    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] d);
        for (int i = 31; i >= 0; i--) begin
            logic fb;
            fb = c[31] ^ d[i];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ POLY_TB;
        end
        return c;
    endfunction

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr ^ (lfsr << 7);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_req(input int sel, input logic v);
        req_io   = (sel == 0) ? v : 1'b0;
        req_ovf  = (sel == 1) ? v : 1'b0;
        req_intv = (sel == 2) ? v : 1'b0;
    endtask

    initial begin
        tick(); tick();
        check(commit_stall == 0 && local_fp_vld == 0 && fp_match == 0 && fp_error == 0,
              "R1 flags in reset", {28'd0, commit_stall, local_fp_vld, fp_match, fp_error}, 32'd0);
        check(local_fp == 32'hFFFFFFFF, "R1 seed in reset", local_fp, 32'hFFFFFFFF);
        rst = 1'b0;
        tick();
        check(commit_stall == 0 && fp_match == 0 && fp_error == 0, "R1 flags after reset",
              {29'd0, commit_stall, fp_match, fp_error}, 32'd0);
        check(local_fp == 32'hFFFFFFFF, "R1 seed after reset", local_fp, 32'hFFFFFFFF);

        // folding sweep over all valid combinations
        for (int i = 0; i < 64; i++) begin
            cm_addr_vld = i[0];
            cm_data_vld = i[1];
            cm_addr = rnd();
            cm_data = rnd();
            tick();
            if (cm_addr_vld) model = ref_crc(model, cm_addr);
            if (cm_data_vld) model = ref_crc(model, cm_data);
            check(local_fp == model, (i % 4 == 3) ? "R3 addr then data" : "R2 fold",
                  local_fp, model);
        end

        // exchanges: every request source, several partner delays, match and mismatch
        tmo_limit = 16'd10;
        for (int sel = 0; sel < 3; sel++) begin
            for (int dly = 0; dly < 4; dly++) begin
                for (int mm = 0; mm < 2; mm++) begin
                    cm_addr_vld = 1'b1; cm_data_vld = 1'b1;
                    cm_addr = rnd(); cm_data = rnd();
                    set_req(sel, 1'b1);
                    tick();
                    model = ref_crc(ref_crc(model, cm_addr), cm_data);
                    check(commit_stall && local_fp_vld, "R4 stall after request",
                          {30'd0, commit_stall, local_fp_vld}, 32'd3);
                    check(local_fp == model, "R5 same-cycle items included", local_fp, model);
                    for (int k = 0; k < dly; k++) begin
                        cm_addr = rnd(); cm_data = rnd();
                        set_req((sel + k) % 3, 1'b1);
                        tick();
                        check(commit_stall == 1, "R4 stall held", {31'd0, commit_stall}, 32'd1);
                        check(local_fp == model, "R5 items ignored in stall", local_fp, model);
                    end
                    set_req(sel, (dly % 2) == 1);
                    peer_fp = (mm == 1) ? (model ^ 32'h0000_0100) : model;
                    peer_fp_vld = 1'b1;
                    tick();
                    peer_fp_vld = 1'b0;
                    set_req(0, 1'b0);
                    cm_addr_vld = 1'b0; cm_data_vld = 1'b0;
                    if (mm == 1) begin
                        check(fp_error == 1 && fp_match == 0, "R7 mismatch error",
                              {30'd0, fp_match, fp_error}, 32'd1);
                    end else begin
                        check(fp_match == 1 && fp_error == 0, "R6 match pulse",
                              {30'd0, fp_match, fp_error}, 32'd2);
                    end
                    check(commit_stall == 0, "R4 stall drops with outcome",
                          {31'd0, commit_stall}, 32'd0);
                    model = 32'hFFFFFFFF;
                    check(local_fp == model, mm ? "R7 restart" : "R6 restart", local_fp, model);
                    tick();
                    check(fp_match == 0 && fp_error == 0, "R10 single pulse",
                          {30'd0, fp_match, fp_error}, 32'd0);
                    check(commit_stall == 0, "R9 late request ignored",
                          {31'd0, commit_stall}, 32'd0);
                end
            end
        end

        // timeout sweep
        for (int lim = 0; lim < 6; lim++) begin
            int n;
            logic got_err;
            tmo_limit = lim[15:0];
            set_req(lim % 3, 1'b1);
            tick();
            set_req(0, 1'b0);
            n = 0;
            got_err = 1'b0;
            while (commit_stall && n < 20) begin
                tick();
                n++;
            end
            got_err = fp_error;
            check(n == lim + 1, "R8 stall length", n, lim + 1);
            check(got_err == 1 && fp_match == 0, "R8 timeout error",
                  {30'd0, fp_match, got_err}, 32'd1);
            check(local_fp == 32'hFFFFFFFF, "R8 restart after timeout", local_fp, 32'hFFFFFFFF);
            tick();
        end

        // partner arrives in the expiry cycle: match wins
        for (int lim = 0; lim < 4; lim++) begin
            tmo_limit = lim[15:0];
            req_intv = 1'b1;
            tick();
            req_intv = 1'b0;
            for (int k = 0; k < lim; k++) tick();
            peer_fp = 32'hFFFFFFFF;
            peer_fp_vld = 1'b1;
            tick();
            peer_fp_vld = 1'b0;
            check(fp_match == 1 && fp_error == 0, "R8 partner beats timeout",
                  {30'd0, fp_match, fp_error}, 32'd2);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule